// File: doc/BRIEF.md
# Interleaved I/Q Decimation Chain

This block lowers the sample rate of a complex baseband stream by 16. Each input word carries one complex sample, with the in-phase part in the low half and the quadrature part in the high half. A width converter splits every word into two beats, I first and then Q. That alternating stream runs through a single time-shared filter datapath. The datapath is a three-stage cascaded integrator-comb decimator by 8, followed by an 11-tap half-band filter that decimates by 2. Both filters keep separate state for the two channels and pick it by beat parity.

A second width converter joins each filtered I/Q pair back into one word. Every output word is marked as a packet end. Input and output both use valid/ready/data/last handshakes.

The downstream consumer is expected to always accept. When the output ready does drop, the whole chain freezes in place, holding the output word and refusing input until the word is taken. The input last flag is overridden: every accepted word counts as a complete packet.

Top module: `iq_decim_chain`

## Requirements
- R1: Out of reset, m_valid_o is low and s_ready_o is high when m_ready_i is high.
- R2: Bits [W-1:0] of an input word are the I sample and bits [2W-1:W] are the Q sample. Each word occupies two beats, so input words are never accepted on two consecutive cycles.
- R3: Per channel, the integrator-comb stage emits one value for every 8 input samples, at samples 8m+7. Each value is the input convolved with three cascaded 8-long boxcars, shifted right arithmetically by 9 bits, so the gain is exactly 1.
- R4: Per channel, the half-band stage emits one value for every two integrator-comb outputs, at odd indices. Its taps are 3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3. The sum is shifted right arithmetically by 9 and kept to W bits.
- R5: Each output word carries I in bits [W-1:0] and Q in bits [2W-1:W]. Exactly one word is produced for every 16 accepted input words, and never on two consecutive handshakes.
- R6: m_last_o is 1 with every valid output word, and s_last_i has no effect on the output.
- R7: While m_valid_o is high and m_ready_i is low, m_valid_o and m_data_o hold and s_ready_o is low.
- R8: A constant input on both channels yields outputs equal to that constant once the filters have filled.
- R9: The channels are independent: a signal on I alone leaves every Q output at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Input word valid |
| s_ready_o | output | 1 | Input word accepted this cycle when valid |
| s_data_i | input | 2*W | Packed complex input, Q high and I low |
| s_last_i | input | 1 | Input packet end (overridden) |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Consumer ready |
| m_data_o | output | 2*W | Packed complex output, Q high and I low |
| m_last_o | output | 1 | Packet end, set on every output word |

## Verification
The bench builds the block with its defaults: W of 16, three stages and a ratio of 8. With those values the combined impulse response is short, 22 taps for the integrator-comb stage and 11 for the half-band. The bench can therefore recompute every output exactly from the stimulus, using a plain integer convolution. Streams of 256 to 512 words cover DC, a single impulse, the alternating Nyquist pattern and pseudo-random data, under several input gap and output stall patterns. Every filter output in each stream is compared.

// File: rtl/iq_decim_pkg.sv
package iq_decim_pkg;
  localparam int HB_TAPS  = 11;
  localparam int HB_SHIFT = 9;

  // half-band: every other tap zero except the centre, taps sum to 2**HB_SHIFT
  function automatic int hb_coef(input int idx);
    case (idx)
      0, 10:   return 3;
      2, 8:    return -25;
      4, 6:    return 150;
      5:       return 256;
      default: return 0;
    endcase
  endfunction

  typedef enum logic {CH_I = 1'b0, CH_Q = 1'b1} chan_e;
endpackage

// File: rtl/iq_beat_split.sv
module iq_beat_split #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [2*W-1:0]      s_data_i,
  output logic                b_valid_o,
  output logic                b_q_o,
  output logic                b_last_o,
  output logic signed [W-1:0] b_data_o
);
  import iq_decim_pkg::*;

  logic [2*W-1:0] hold_q;
  logic           full_q;
  chan_e          ph_q;
  logic           take;

  assign s_ready_o = en_i & (~full_q | (ph_q == CH_Q));
  assign take      = s_valid_i & s_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
      ph_q   <= CH_I;
    end else if (en_i) begin
      if (take) begin
        hold_q <= s_data_i;
        full_q <= 1'b1;
        ph_q   <= CH_I;
      end else if (full_q) begin
        if (ph_q == CH_Q) begin
          full_q <= 1'b0;
          ph_q   <= CH_I;
        end else begin
          ph_q <= CH_Q;
        end
      end
    end
  end

  assign b_valid_o = full_q;
  assign b_q_o     = (ph_q == CH_Q);
  // packet end forced on every word: it lands on the Q beat
  assign b_last_o  = (ph_q == CH_Q);
  assign b_data_o  = (ph_q == CH_Q) ? hold_q[2*W-1:W] : hold_q[W-1:0];
endmodule

// File: rtl/iq_cic_decim.sv
module iq_cic_decim #(
  parameter int W      = 16,
  parameter int STAGES = 3,
  parameter int RATIO  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                in_valid_i,
  input  logic                in_q_i,
  input  logic                in_last_i,
  input  logic signed [W-1:0] in_data_i,
  output logic                o_valid_o,
  output logic                o_q_o,
  output logic                o_last_o,
  output logic signed [W-1:0] o_data_o
);
  localparam int LW   = $clog2(RATIO);
  localparam int GROW = STAGES * LW;
  localparam int AW   = W + GROW;

  logic signed [AW-1:0] integ_q [2][STAGES];
  logic signed [AW-1:0] dly_q   [2][STAGES];
  logic signed [AW-1:0] i_nxt   [STAGES];
  logic signed [AW-1:0] c_val   [STAGES];
  logic [LW-1:0]        cnt_q;
  logic                 ch;
  logic                 fire;
  logic                 dump;
  logic [GROW-1:0]      unused_frac;

  assign ch          = in_q_i;
  assign fire        = en_i & in_valid_i;
  assign dump        = fire & (cnt_q == LW'(RATIO - 1));
  assign unused_frac = c_val[STAGES-1][GROW-1:0];

  always_comb begin
    i_nxt[0] = integ_q[ch][0] + AW'(in_data_i);
    for (int s = 1; s < STAGES; s++) i_nxt[s] = integ_q[ch][s] + i_nxt[s-1];
    c_val[0] = i_nxt[STAGES-1] - dly_q[ch][0];
    for (int s = 1; s < STAGES; s++) c_val[s] = c_val[s-1] - dly_q[ch][s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        for (int s = 0; s < STAGES; s++) begin
          integ_q[c][s] <= '0;
          dly_q[c][s]   <= '0;
        end
      end
      cnt_q     <= '0;
      o_valid_o <= 1'b0;
      o_q_o     <= 1'b0;
      o_last_o  <= 1'b0;
      o_data_o  <= '0;
    end else begin
      if (fire) begin
        for (int s = 0; s < STAGES; s++) integ_q[ch][s] <= i_nxt[s];
        if (in_q_i) cnt_q <= (cnt_q == LW'(RATIO - 1)) ? '0 : cnt_q + 1'b1;
      end
      if (dump) begin
        dly_q[ch][0] <= i_nxt[STAGES-1];
        for (int s = 1; s < STAGES; s++) dly_q[ch][s] <= c_val[s-1];
      end
      if (en_i) begin
        o_valid_o <= dump;
        if (dump) begin
          o_data_o <= c_val[STAGES-1][AW-1 -: W];
          o_q_o    <= in_q_i;
          o_last_o <= in_last_i;
        end
      end
    end
  end
endmodule

// File: rtl/iq_hb_fir.sv
module iq_hb_fir #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                in_valid_i,
  input  logic                in_q_i,
  input  logic                in_last_i,
  input  logic signed [W-1:0] in_data_i,
  output logic                o_valid_o,
  output logic                o_q_o,
  output logic                o_last_o,
  output logic signed [W-1:0] o_data_o
);
  import iq_decim_pkg::*;

  localparam int TAPS  = HB_TAPS;
  localparam int ACC_W = W + 12;

  logic signed [W-1:0]     dl_q [2][TAPS-1];
  logic [1:0]              ph_q;
  logic signed [W-1:0]     win  [TAPS];
  logic signed [ACC_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] acc;
  logic                    ch;
  logic                    fire;
  logic                    emit;
  logic [ACC_W-W-1:0]      unused_acc;

  assign ch         = in_q_i;
  assign fire       = en_i & in_valid_i;
  assign emit       = fire & ph_q[ch];
  assign unused_acc = {acc[ACC_W-1:HB_SHIFT+W], acc[HB_SHIFT-1:0]};

  always_comb begin
    win[0] = in_data_i;
    for (int j = 1; j < TAPS; j++) win[j] = dl_q[ch][j-1];
  end

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    assign prod[j] = ACC_W'(hb_coef(j)) * ACC_W'(win[j]);
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < TAPS; j++) acc = acc + prod[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++)
        for (int j = 0; j < TAPS-1; j++) dl_q[c][j] <= '0;
      ph_q      <= '0;
      o_valid_o <= 1'b0;
      o_q_o     <= 1'b0;
      o_last_o  <= 1'b0;
      o_data_o  <= '0;
    end else begin
      if (fire) begin
        dl_q[ch][0] <= in_data_i;
        for (int j = 1; j < TAPS-1; j++) dl_q[ch][j] <= dl_q[ch][j-1];
        ph_q[ch] <= ~ph_q[ch];
      end
      if (en_i) begin
        o_valid_o <= emit;
        if (emit) begin
          o_data_o <= acc[HB_SHIFT +: W];
          o_q_o    <= in_q_i;
          o_last_o <= in_last_i;
        end
      end
    end
  end
endmodule

// File: rtl/iq_beat_pack.sv
module iq_beat_pack #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                in_valid_i,
  input  logic                in_q_i,
  input  logic                in_last_i,
  input  logic signed [W-1:0] in_data_i,
  output logic                m_valid_o,
  output logic [2*W-1:0]      m_data_o,
  output logic                m_last_o
);
  logic [W-1:0] i_hold_q;
  logic         i_have_q;
  logic         fire;
  logic         pair;

  assign fire = en_i & in_valid_i;
  assign pair = fire & in_q_i & i_have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_hold_q  <= '0;
      i_have_q  <= 1'b0;
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
      m_last_o  <= 1'b0;
    end else if (en_i) begin
      if (fire) begin
        if (!in_q_i) begin
          i_hold_q <= in_data_i;
          i_have_q <= 1'b1;
        end else begin
          i_have_q <= 1'b0;
        end
      end
      m_valid_o <= pair;
      if (pair) begin
        m_data_o <= {in_data_i, i_hold_q};
        m_last_o <= in_last_i;
      end
    end
  end
endmodule

// File: rtl/iq_decim_chain.sv
module iq_decim_chain #(
  parameter int W      = 16,
  parameter int STAGES = 3,
  parameter int RATIO  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           s_valid_i,
  output logic           s_ready_o,
  input  logic [2*W-1:0] s_data_i,
  input  logic           s_last_i,
  output logic           m_valid_o,
  input  logic           m_ready_i,
  output logic [2*W-1:0] m_data_o,
  output logic           m_last_o
);
  logic                en;
  logic                unused_last;
  logic                sp_valid, sp_q, sp_last;
  logic signed [W-1:0] sp_data;
  logic                cic_valid, cic_q, cic_last;
  logic signed [W-1:0] cic_data;
  logic                fir_valid, fir_q, fir_last;
  logic signed [W-1:0] fir_data;

  // global stall: the whole chain freezes while an output word waits
  assign en          = ~(m_valid_o & ~m_ready_i);
  assign unused_last = s_last_i;

  iq_beat_split #(.W(W)) split_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
    .b_valid_o(sp_valid), .b_q_o(sp_q), .b_last_o(sp_last), .b_data_o(sp_data)
  );

  iq_cic_decim #(.W(W), .STAGES(STAGES), .RATIO(RATIO)) cic_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .in_valid_i(sp_valid), .in_q_i(sp_q), .in_last_i(sp_last), .in_data_i(sp_data),
    .o_valid_o(cic_valid), .o_q_o(cic_q), .o_last_o(cic_last), .o_data_o(cic_data)
  );

  iq_hb_fir #(.W(W)) fir_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .in_valid_i(cic_valid), .in_q_i(cic_q), .in_last_i(cic_last), .in_data_i(cic_data),
    .o_valid_o(fir_valid), .o_q_o(fir_q), .o_last_o(fir_last), .o_data_o(fir_data)
  );

  iq_beat_pack #(.W(W)) pack_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .in_valid_i(fir_valid), .in_q_i(fir_q), .in_last_i(fir_last), .in_data_i(fir_data),
    .m_valid_o(m_valid_o), .m_data_o(m_data_o), .m_last_o(m_last_o)
  );
endmodule

// File: rtl/iq_decim_chain_chk.sv
module iq_decim_chain_chk #(
  parameter int W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           s_valid_i,
  input logic           s_ready_o,
  input logic           m_valid_o,
  input logic           m_ready_i,
  input logic [2*W-1:0] m_data_o,
  input logic           m_last_o
);
  a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  a_r5_sparse_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i) |=> !m_valid_o);

  a_r6_last_each_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> m_last_o);

  a_r7_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

  a_r7_no_take_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |-> !s_ready_o);
endmodule

bind iq_decim_chain iq_decim_chain_chk #(.W(W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_data_o(m_data_o), .m_last_o(m_last_o)
);

// File: tb/iq_decim_chain_tb_top.sv
module iq_decim_chain_tb_top;
  localparam int W    = 16;
  localparam int NMAX = 512;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           s_valid_i = 1'b0;
  logic           s_ready_o;
  logic [2*W-1:0] s_data_i = '0;
  logic           s_last_i = 1'b0;
  logic           m_valid_o;
  logic           m_ready_i = 1'b1;
  logic [2*W-1:0] m_data_o;
  logic           m_last_o;

  always #10 clk_i = ~clk_i;

  iq_decim_chain #(.W(W), .STAGES(3), .RATIO(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .s_data_i(s_data_i), .s_last_i(s_last_i), .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i), .m_data_o(m_data_o), .m_last_o(m_last_o)
  );

  int n_total = 0;
  int n_bad   = 0;
  int xi [NMAX];
  int xq [NMAX];
  int nw;
  int got_i [64];
  int got_q [64];
  int n_got;
  int hc [22];
  int hf [11] = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};
  int cyc_all = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cic_ref(input bit ch, input int m);
    longint s = 0;
    logic signed [15:0] t;
    for (int k = 0; k < 22; k++) begin
      int idx = 8*m + 7 - k;
      if (idx >= 0 && idx < nw) s += longint'(hc[k]) * (ch ? xq[idx] : xi[idx]);
    end
    t = 16'(s >>> 9);
    return int'(t);
  endfunction

  function automatic int fir_ref(input bit ch, input int p);
    longint s = 0;
    logic signed [15:0] t;
    for (int j = 0; j < 11; j++) begin
      int m = 2*p + 1 - j;
      if (m >= 0) s += longint'(hf[j]) * cic_ref(ch, m);
    end
    t = 16'(s >>> 9);
    return int'(t);
  endfunction

  task automatic do_reset();
    s_valid_i = 1'b0;
    m_ready_i = 1'b1;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one process drives every input and samples 1 ns after the falling edge
  task automatic run(input int gap_mode, input int rdy_mode);
    int k = 0;
    int drain = 0;
    int cyc = 0;
    bit prev_take = 1'b0;
    bit prev_stall = 1'b0;
    logic [2*W-1:0] prev_word = '0;
    n_got = 0;
    while (k < nw || drain < 400) begin
      bit take;
      @(negedge clk_i);
      case (rdy_mode)
        0:       m_ready_i = 1'b1;
        1:       m_ready_i = (cyc % 3) != 0;
        default: m_ready_i = (cyc % 7) > 4;
      endcase
      s_valid_i = (k < nw) && (gap_mode == 0 || (cyc % 5) != 2);
      if (k < nw) s_data_i = {16'(xq[k]), 16'(xi[k])};
      s_last_i = cyc[0] ^ cyc[2];
      #1;
      if (prev_stall) chk("R7 held word", int'(m_data_o), int'(prev_word));
      prev_stall = m_valid_o && !m_ready_i;
      prev_word  = m_data_o;
      if (m_valid_o && m_ready_i) begin
        chk("R6 last flag", int'(m_last_o), 1);
        if (n_got < 64) begin
          got_i[n_got] = int'($signed(m_data_o[15:0]));
          got_q[n_got] = int'($signed(m_data_o[31:16]));
        end
        n_got++;
      end
      take = s_valid_i && s_ready_o;
      if (take && prev_take) chk("R2 back to back accept", 1, 0);
      prev_take = take;
      if (take) k++;
      if (k >= nw) drain++;
      cyc++;
    end
    s_valid_i = 1'b0;
    m_ready_i = 1'b1;
  endtask

  task automatic compare(input string name);
    chk({name, " R5 word count"}, n_got, nw / 16);
    for (int p = 0; p < n_got && p < 64; p++) begin
      chk({name, " R3 R4 R5 I"}, got_i[p], fir_ref(1'b0, p));
      chk({name, " R3 R4 R5 Q"}, got_q[p], fir_ref(1'b1, p));
    end
  endtask

  always @(posedge clk_i) begin
    cyc_all++;
    if (cyc_all > 150000 && !done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_all);
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    int a8 [8];
    int a15 [15];
    logic [15:0] lfsr;
    for (int i = 0; i < 8; i++) a8[i] = 1;
    for (int i = 0; i < 15; i++) a15[i] = 0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) a15[i+j] += a8[i];
    for (int i = 0; i < 22; i++) hc[i] = 0;
    for (int i = 0; i < 15; i++) for (int j = 0; j < 8; j++) hc[i+j] += a15[i];

    // R1 reset state
    do_reset();
    #1;
    chk("R1 m_valid_o after reset", int'(m_valid_o), 0);
    chk("R1 s_ready_o after reset", int'(s_ready_o), 1);

    // R8 DC on both channels
    nw = 256;
    for (int i = 0; i < nw; i++) begin xi[i] = 1000; xq[i] = -7000; end
    do_reset();
    run(0, 0);
    compare("dc");
    chk("R8 dc I settled", got_i[15], 1000);
    chk("R8 dc Q settled", got_q[15], -7000);

    // R9 impulse on I only, stalled output
    nw = 256;
    for (int i = 0; i < nw; i++) begin xi[i] = 0; xq[i] = 0; end
    xi[3] = 20000;
    do_reset();
    run(0, 1);
    compare("impulse");
    for (int p = 0; p < 16; p++) chk("R9 Q stays zero", got_q[p], 0);

    // alternating sign at Nyquist with input gaps
    nw = 256;
    for (int i = 0; i < nw; i++) begin
      xi[i] = (i % 2) ? 12000 : -12000;
      xq[i] = (i % 2) ? -9000 : 9000;
    end
    do_reset();
    run(1, 0);
    compare("nyquist");

    // pseudo-random with gaps and heavy backpressure
    nw = 512;
    lfsr = 16'hACE1;
    for (int i = 0; i < nw; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xi[i] = int'($signed(lfsr)) / 2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xq[i] = int'($signed(lfsr)) / 2;
    end
    do_reset();
    run(1, 2);
    compare("random");

    // ramp on Q, negative DC on I
    nw = 384;
    for (int i = 0; i < nw; i++) begin xi[i] = -3; xq[i] = i * 50 - 9000; end
    do_reset();
    run(0, 1);
    compare("ramp");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule